// File: doc/BRIEF.md
# ADC Pulse Summary Extractor

This block watches the 12-bit sample stream of one drift-chamber channel during a hit window and reduces the pulse to four small numbers for readout: a halved and clamped integral, a peak value scaled down by eight, a pedestal taken as the mean of the opening samples, and a saturating count of samples that hit ADC full scale. A start strobe opens the window and clears every accumulator, an end strobe closes it, and one cycle later the results appear together with a single-cycle valid pulse.

The same results are also delivered packed into two readout words, a 15-bit one and a 31-bit one, with unused bits driven low. Each field has its own shift and saturation rule, so a field that would exceed its budget shows its all-ones code rather than a wrapped value. Results stay on the outputs until the next window end.

Top module: `pulse_summary_top`

## Requirements
- R1: While reset is applied and after its release, `res_valid` is 0 and every result field and both readout words are 0 until the first window end.
- R2: `res_valid` is high for exactly the one cycle following each cycle in which `win_end` is high, and low in all other cycles.
- R3: `res_integral` equals the sum of the samples accepted in the window, where the running sum saturates at 2^20-1, shifted right by one and clamped to 65535.
- R4: `res_peak` equals the largest accepted sample of the window shifted right by 3 (so 4095 reports 511).
- R5: `res_pedestal` equals the sum of the first four accepted samples of the window (fewer if the window held fewer) shifted right by 2, reported as 255 when that value is 255 or more.
- R6: `res_overflows` counts accepted samples equal to 4095, stops at 7, and 7 means seven or more.
- R7: A sample is accepted only when `smp_valid` is high and either a window is open or `win_start` is high in that cycle; a `win_start`, even inside an open window, discards everything gathered before it.
- R8: `rd_word0` holds the peak in bits 8:0, the overflow count in bits 11:9, and zeros in bits 14:12.
- R9: `rd_word1` holds the integral in bits 15:0, the pedestal in bits 23:16, and zeros in bits 30:24.
- R10: Between result pulses all result fields and both words keep their last value.
- R11: A sample presented in the `win_start` cycle is the first sample of the window, a sample presented in the `win_end` cycle is the last one, and a cycle with both strobes forms a window of that single sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 12 | ADC sample, 0 to 4095 |
| win_start | input | 1 | Opens a window and clears accumulators |
| win_end | input | 1 | Closes the window and requests results |
| res_valid | output | 1 | One-cycle result pulse |
| res_integral | output | 16 | Halved, clamped integral |
| res_peak | output | 9 | Peak divided by 8 |
| res_pedestal | output | 8 | Pedestal, clamped to 255 |
| res_overflows | output | 3 | Full-scale sample count, 7 = seven or more |
| rd_word0 | output | 15 | Packed peak and overflow count |
| rd_word1 | output | 31 | Packed integral and pedestal |

## Verification
The bench builds the block with its default parameters: a 20-bit accumulator, a four-sample pedestal, a shift of three on the peak and the 15/31-bit word budgets. With these values a window of forty samples near 4000 reaches the integral clamp, a window of three hundred full-scale samples drives the running sum into its own saturation, ten full-scale samples pin the overflow count at 7, and opening samples near 1000 force the pedestal clamp. Restarts inside an open window, single-sample windows and samples arriving outside any window are all reachable within a few hundred cycles.

// File: rtl/pulse_summary_pkg.sv
package pulse_summary_pkg;

   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_t;

   localparam int DEF_SAMPLE_W = 12;
   localparam int DEF_ACC_W    = 20;

endpackage

// File: rtl/ps_window_ctrl.sv
module ps_window_ctrl
   import pulse_summary_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   input  logic win_start,
   input  logic win_end,
   output logic accept,
   output logic clear,
   output logic report,
   output logic in_win
);

   win_state_t st_q;
   win_state_t st_d;

   always_comb begin
      st_d = st_q;
      if (win_end)
         st_d = WIN_IDLE;
      else if (win_start)
         st_d = WIN_OPEN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= WIN_IDLE;
      else
         st_q <= st_d;
   end

   assign in_win = (st_q == WIN_OPEN);
   assign accept = smp_valid && (in_win || win_start);
   assign clear  = win_start;
   assign report = win_end;

   // R7: a window that was closed stays closed unless a start arrives
   assert_closed_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_win && !win_start) |=> !in_win);

endmodule

// File: rtl/ps_integrator.sv
module ps_integrator #(
   parameter int SAMPLE_W = 12,
   parameter int ACC_W    = 20,
   parameter int OVF_W    = 3,
   parameter bit ACC_SAT  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                accept,
   input  logic [SAMPLE_W-1:0] sample,
   output logic [ACC_W-1:0]    acc_nxt,
   output logic [OVF_W-1:0]    ovf_nxt
);

   localparam logic [SAMPLE_W-1:0] FULL_SCALE = {SAMPLE_W{1'b1}};
   localparam logic [OVF_W-1:0]    OVF_MAX    = {OVF_W{1'b1}};

   logic [ACC_W-1:0] acc_q;
   logic [OVF_W-1:0] ovf_q;
   logic [ACC_W-1:0] acc_base;
   logic [OVF_W-1:0] ovf_base;
   logic [ACC_W:0]   acc_sum;

   assign acc_base = clear ? '0 : acc_q;
   assign ovf_base = clear ? '0 : ovf_q;
   assign acc_sum  = {1'b0, acc_base} + {{(ACC_W + 1 - SAMPLE_W){1'b0}}, sample};

   generate
      if (ACC_SAT) begin : g_acc_sat
         always_comb begin
            if (!accept)
               acc_nxt = acc_base;
            else if (acc_sum[ACC_W])
               acc_nxt = {ACC_W{1'b1}};
            else
               acc_nxt = acc_sum[ACC_W-1:0];
         end

         // R3: the saturating sum never falls inside a window
         assert_acc_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> acc_q >= $past(acc_q));
      end else begin : g_acc_wrap
         always_comb begin
            acc_nxt = accept ? acc_sum[ACC_W-1:0] : acc_base;
         end
      end
   endgenerate

   always_comb begin
      ovf_nxt = ovf_base;
      if (accept && (sample == FULL_SCALE) && (ovf_base != OVF_MAX))
         ovf_nxt = ovf_base + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= '0;
      end else begin
         acc_q <= acc_nxt;
         ovf_q <= ovf_nxt;
      end
   end

   // R6: the overflow count only grows inside a window and steps by at most one
   assert_ovf_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (ovf_q >= $past(ovf_q)) && (ovf_q - $past(ovf_q) <= 1));

endmodule

// File: rtl/ps_shape_tracker.sv
module ps_shape_tracker #(
   parameter int SAMPLE_W = 12,
   parameter int PED_LOG2 = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         accept,
   input  logic [SAMPLE_W-1:0]          sample,
   output logic [SAMPLE_W-1:0]          peak_nxt,
   output logic [SAMPLE_W+PED_LOG2-1:0] ped_sum_nxt
);

   localparam int PED_N  = 1 << PED_LOG2;
   localparam int CNT_W  = PED_LOG2 + 1;
   localparam int PSUM_W = SAMPLE_W + PED_LOG2;

   logic [SAMPLE_W-1:0] peak_q;
   logic [PSUM_W-1:0]   ped_sum_q;
   logic [CNT_W-1:0]    ped_cnt_q;
   logic [SAMPLE_W-1:0] peak_base;
   logic [PSUM_W-1:0]   psum_base;
   logic [CNT_W-1:0]    pcnt_base;
   logic [CNT_W-1:0]    ped_cnt_nxt;

   assign peak_base = clear ? '0 : peak_q;
   assign psum_base = clear ? '0 : ped_sum_q;
   assign pcnt_base = clear ? '0 : ped_cnt_q;

   always_comb begin
      peak_nxt = peak_base;
      if (accept && (sample > peak_base))
         peak_nxt = sample;
   end

   always_comb begin
      ped_sum_nxt = psum_base;
      ped_cnt_nxt = pcnt_base;
      if (accept && (pcnt_base < CNT_W'(PED_N))) begin
         ped_sum_nxt = psum_base + {{PED_LOG2{1'b0}}, sample};
         ped_cnt_nxt = pcnt_base + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak_q    <= '0;
         ped_sum_q <= '0;
         ped_cnt_q <= '0;
      end else begin
         peak_q    <= peak_nxt;
         ped_sum_q <= ped_sum_nxt;
         ped_cnt_q <= ped_cnt_nxt;
      end
   end

   // R4: after an accepted sample the running maximum is at least that sample
   assert_peak_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> peak_q >= $past(sample));

   // R5: the pedestal never gathers more than its opening samples
   assert_ped_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ped_cnt_q <= CNT_W'(PED_N));

endmodule

// File: rtl/ps_formatter.sv
module ps_formatter #(
   parameter int SAMPLE_W   = 12,
   parameter int ACC_W      = 20,
   parameter int OVF_W      = 3,
   parameter int PED_LOG2   = 2,
   parameter int INT_OUT_W  = 16,
   parameter int PED_OUT_W  = 8,
   parameter int PEAK_SHIFT = 3,
   parameter int WORD0_W    = 15,
   parameter int WORD1_W    = 31
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          report,
   input  logic [ACC_W-1:0]              acc_nxt,
   input  logic [OVF_W-1:0]              ovf_nxt,
   input  logic [SAMPLE_W-1:0]           peak_nxt,
   input  logic [SAMPLE_W+PED_LOG2-1:0]  ped_sum_nxt,
   output logic                          res_valid,
   output logic [INT_OUT_W-1:0]          res_integral,
   output logic [SAMPLE_W-PEAK_SHIFT-1:0] res_peak,
   output logic [PED_OUT_W-1:0]          res_pedestal,
   output logic [OVF_W-1:0]              res_overflows,
   output logic [WORD0_W-1:0]            rd_word0,
   output logic [WORD1_W-1:0]            rd_word1
);

   localparam int PEAK_OUT_W = SAMPLE_W - PEAK_SHIFT;
   localparam int SPARE0     = WORD0_W - PEAK_OUT_W - OVF_W;
   localparam int SPARE1     = WORD1_W - INT_OUT_W - PED_OUT_W;
   localparam logic [ACC_W-2:0] INT_LIM =
      {{(ACC_W - 1 - INT_OUT_W){1'b0}}, {INT_OUT_W{1'b1}}};
   localparam logic [SAMPLE_W-1:0] PED_LIM =
      {{(SAMPLE_W - PED_OUT_W){1'b0}}, {PED_OUT_W{1'b1}}};

   logic [ACC_W-2:0]       int_half;
   logic [INT_OUT_W-1:0]   int_fmt;
   logic [SAMPLE_W-1:0]    ped_avg;
   logic [PED_OUT_W-1:0]   ped_fmt;
   logic [PEAK_OUT_W-1:0]  peak_fmt;
   logic                   valid_q;
   logic [INT_OUT_W-1:0]   int_q;
   logic [PEAK_OUT_W-1:0]  peak_q;
   logic [PED_OUT_W-1:0]   ped_q;
   logic [OVF_W-1:0]       ovf_q;

   assign int_half = acc_nxt[ACC_W-1:1];
   assign int_fmt  = (int_half > INT_LIM) ? {INT_OUT_W{1'b1}} : int_half[INT_OUT_W-1:0];

   assign ped_avg  = ped_sum_nxt[SAMPLE_W+PED_LOG2-1:PED_LOG2];
   assign ped_fmt  = (ped_avg > PED_LIM) ? {PED_OUT_W{1'b1}} : ped_avg[PED_OUT_W-1:0];

   generate
      if (PEAK_SHIFT == 0) begin : g_peak_direct
         assign peak_fmt = peak_nxt;
      end else begin : g_peak_shift
         assign peak_fmt = peak_nxt[SAMPLE_W-1:PEAK_SHIFT];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         int_q   <= '0;
         peak_q  <= '0;
         ped_q   <= '0;
         ovf_q   <= '0;
      end else begin
         valid_q <= report;
         if (report) begin
            int_q  <= int_fmt;
            peak_q <= peak_fmt;
            ped_q  <= ped_fmt;
            ovf_q  <= ovf_nxt;
         end
      end
   end

   assign res_valid     = valid_q;
   assign res_integral  = int_q;
   assign res_peak      = peak_q;
   assign res_pedestal  = ped_q;
   assign res_overflows = ovf_q;

   generate
      if (SPARE0 > 0) begin : g_w0_pad
         assign rd_word0 = {{SPARE0{1'b0}}, ovf_q, peak_q};
      end else begin : g_w0_full
         assign rd_word0 = {ovf_q, peak_q};
      end
      if (SPARE1 > 0) begin : g_w1_pad
         assign rd_word1 = {{SPARE1{1'b0}}, ped_q, int_q};
      end else begin : g_w1_full
         assign rd_word1 = {ped_q, int_q};
      end
   endgenerate

   // R2: every window end produces a pulse in the following cycle
   assert_valid_follows_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      report |=> res_valid);

   // R2: no pulse without a window end in the cycle before
   assert_valid_needs_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(report));

   // R10: fields hold while no result is taken
   assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !report |=> ($stable(res_integral) && $stable(res_peak) &&
                   $stable(res_pedestal) && $stable(res_overflows)));

endmodule

// File: rtl/pulse_summary_top.sv
module pulse_summary_top #(
   parameter int SAMPLE_W   = 12,
   parameter int ACC_W      = 20,
   parameter int OVF_W      = 3,
   parameter int PED_LOG2   = 2,
   parameter int INT_OUT_W  = 16,
   parameter int PED_OUT_W  = 8,
   parameter int PEAK_SHIFT = 3,
   parameter int WORD0_W    = 15,
   parameter int WORD1_W    = 31,
   parameter bit ACC_SAT    = 1'b1,
   localparam int PEAK_OUT_W = SAMPLE_W - PEAK_SHIFT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_valid,
   input  logic [SAMPLE_W-1:0]    smp_data,
   input  logic                   win_start,
   input  logic                   win_end,
   output logic                   res_valid,
   output logic [INT_OUT_W-1:0]   res_integral,
   output logic [PEAK_OUT_W-1:0]  res_peak,
   output logic [PED_OUT_W-1:0]   res_pedestal,
   output logic [OVF_W-1:0]       res_overflows,
   output logic [WORD0_W-1:0]     rd_word0,
   output logic [WORD1_W-1:0]     rd_word1
);

   localparam int PSUM_W = SAMPLE_W + PED_LOG2;

   generate
      if (ACC_W < INT_OUT_W + 2) begin : g_bad_acc
         $error("accumulator too narrow for the integral field");
      end
      if (SAMPLE_W <= PED_OUT_W) begin : g_bad_ped
         $error("pedestal field must be narrower than a sample");
      end
      if (PEAK_SHIFT >= SAMPLE_W) begin : g_bad_peak
         $error("peak shift removes every bit");
      end
      if (PEAK_OUT_W + OVF_W > WORD0_W) begin : g_bad_w0
         $error("first readout word too small");
      end
      if (INT_OUT_W + PED_OUT_W > WORD1_W) begin : g_bad_w1
         $error("second readout word too small");
      end
      if (OVF_W < 1 || PED_LOG2 < 0) begin : g_bad_misc
         $error("invalid counter parameters");
      end
   endgenerate

   logic                accept;
   logic                clear;
   logic                report;
   logic                in_win;
   logic [ACC_W-1:0]    acc_nxt;
   logic [OVF_W-1:0]    ovf_nxt;
   logic [SAMPLE_W-1:0] peak_nxt;
   logic [PSUM_W-1:0]   ped_sum_nxt;

   ps_window_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .win_start (win_start),
      .win_end   (win_end),
      .accept    (accept),
      .clear     (clear),
      .report    (report),
      .in_win    (in_win)
   );

   ps_integrator #(
      .SAMPLE_W (SAMPLE_W),
      .ACC_W    (ACC_W),
      .OVF_W    (OVF_W),
      .ACC_SAT  (ACC_SAT)
   ) u_integ (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .accept  (accept),
      .sample  (smp_data),
      .acc_nxt (acc_nxt),
      .ovf_nxt (ovf_nxt)
   );

   ps_shape_tracker #(
      .SAMPLE_W (SAMPLE_W),
      .PED_LOG2 (PED_LOG2)
   ) u_shape (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .accept      (accept),
      .sample      (smp_data),
      .peak_nxt    (peak_nxt),
      .ped_sum_nxt (ped_sum_nxt)
   );

   ps_formatter #(
      .SAMPLE_W   (SAMPLE_W),
      .ACC_W      (ACC_W),
      .OVF_W      (OVF_W),
      .PED_LOG2   (PED_LOG2),
      .INT_OUT_W  (INT_OUT_W),
      .PED_OUT_W  (PED_OUT_W),
      .PEAK_SHIFT (PEAK_SHIFT),
      .WORD0_W    (WORD0_W),
      .WORD1_W    (WORD1_W)
   ) u_fmt (
      .clk           (clk),
      .rst_n         (rst_n),
      .report        (report),
      .acc_nxt       (acc_nxt),
      .ovf_nxt       (ovf_nxt),
      .peak_nxt      (peak_nxt),
      .ped_sum_nxt   (ped_sum_nxt),
      .res_valid     (res_valid),
      .res_integral  (res_integral),
      .res_peak      (res_peak),
      .res_pedestal  (res_pedestal),
      .res_overflows (res_overflows),
      .rd_word0      (rd_word0),
      .rd_word1      (rd_word1)
   );

   // R11: a start and end in the same cycle leave no window open
   assert_single_cycle_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start && win_end) |=> !in_win);

endmodule

// File: tb/pulse_summary_top_tb_top.sv
module pulse_summary_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam longint ACC_MAX = (64'd1 << 20) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic        win_start = 1'b0;
   logic        win_end = 1'b0;
   logic        res_valid;
   logic [15:0] res_integral;
   logic [8:0]  res_peak;
   logic [7:0]  res_pedestal;
   logic [2:0]  res_overflows;
   logic [14:0] rd_word0;
   logic [30:0] rd_word1;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pulse_summary_top dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .smp_valid     (smp_valid),
      .smp_data      (smp_data),
      .win_start     (win_start),
      .win_end       (win_end),
      .res_valid     (res_valid),
      .res_integral  (res_integral),
      .res_peak      (res_peak),
      .res_pedestal  (res_pedestal),
      .res_overflows (res_overflows),
      .rd_word0      (rd_word0),
      .rd_word1      (rd_word1)
   );

   int n_checks = 0;
   int n_errors = 0;
   string scen = "R1";

   // behavioural reference state
   bit     m_open = 0;
   longint m_sum = 0;
   int     m_peak = 0;
   int     m_psum = 0;
   int     m_pcnt = 0;
   int     m_ovf = 0;
   bit     e_valid = 0;
   longint e_int = 0;
   int     e_peak = 0;
   int     e_ped = 0;
   int     e_ovf = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
      end
   endtask

   task automatic model_edge(input bit v, input int d, input bit s, input bit e);
      if (s) begin
         m_sum = 0; m_peak = 0; m_psum = 0; m_pcnt = 0; m_ovf = 0; m_open = 1;
      end
      if (v && m_open) begin
         m_sum = m_sum + d;
         if (m_sum > ACC_MAX) m_sum = ACC_MAX;
         if (d > m_peak) m_peak = d;
         if (m_pcnt < 4) begin m_psum += d; m_pcnt++; end
         if (d == 4095 && m_ovf < 7) m_ovf++;
      end
      e_valid = e;
      if (e) begin
         e_int  = (m_sum >> 1) > 65535 ? 65535 : (m_sum >> 1);
         e_peak = m_peak >> 3;
         e_ped  = (m_psum >> 2) > 255 ? 255 : (m_psum >> 2);
         e_ovf  = m_ovf;
         m_open = 0;
      end
   endtask

   task automatic compare_all();
      longint w0;
      longint w1;
      w0 = (longint'(e_ovf) << 9) | e_peak;
      w1 = (longint'(e_ped) << 16) | e_int;
      chk(res_valid == e_valid, "R2", res_valid, e_valid);
      chk(res_integral == e_int, "R3", res_integral, e_int);
      chk(res_peak == e_peak, "R4", res_peak, e_peak);
      chk(res_pedestal == e_ped, "R5", res_pedestal, e_ped);
      chk(res_overflows == e_ovf, "R6", res_overflows, e_ovf);
      chk(rd_word0 == w0, "R8", rd_word0, w0);
      chk(rd_word1 == w1, "R9", rd_word1, w1);
   endtask

   task automatic step(input bit v, input int d, input bit s, input bit e);
      @(negedge clk);
      smp_valid = v;
      smp_data  = 12'(d);
      win_start = s;
      win_end   = e;
      @(posedge clk);
      model_edge(v, d, s, e);
      #(CLK_PERIOD / 4);
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      for (int c = 0; c < 150000; c++) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : stimulus
      // R1: reset state
      repeat (3) @(posedge clk);
      #(CLK_PERIOD / 4);
      chk(res_valid == 1'b0, "R1", res_valid, 0);
      chk(rd_word0 == '0 && rd_word1 == '0, "R1", rd_word0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      chk(res_integral == '0 && res_pedestal == '0, "R1", res_integral, 0);

      // R11 R3 R4 R5 R6: mixed pulse, sample with start and with end
      scen = "R11";
      step(1, 100, 1, 0);
      step(1, 110, 0, 0);
      step(1, 120, 0, 0);
      step(1, 130, 0, 0);
      step(1, 4095, 0, 0);
      step(0, 999, 0, 0);
      step(1, 200, 0, 0);
      step(1, 4095, 0, 0);
      step(1, 4095, 0, 0);
      step(1, 50, 0, 0);
      step(1, 60, 0, 1);
      idle(3);

      // R6: ten full-scale samples pin count at 7; R5 pedestal clamps
      scen = "R6";
      step(0, 0, 1, 0);
      for (int i = 0; i < 10; i++) step(1, 4095, 0, 0);
      step(0, 0, 0, 1);
      idle(2);

      // R7: samples outside any window are ignored, start clears old peak
      scen = "R7";
      for (int i = 0; i < 5; i++) step(1, 4095, 0, 0);
      step(0, 0, 1, 0);
      for (int i = 1; i <= 5; i++) step(1, 10 * i, 0, 0);
      step(0, 0, 0, 1);
      for (int i = 0; i < 4; i++) step(1, 3000, 0, 0);
      idle(1);

      // R7: restart inside an open window discards the earlier part
      scen = "R7";
      step(1, 3500, 1, 0);
      step(1, 4095, 0, 0);
      step(1, 40, 1, 0);
      step(1, 44, 0, 0);
      step(0, 0, 0, 1);
      idle(2);

      // R3: integral clamp after forty samples near 4000
      scen = "R3";
      step(0, 0, 1, 0);
      for (int i = 0; i < 40; i++) step(1, 4000, 0, 0);
      step(0, 0, 0, 1);
      idle(1);

      // R3: running sum saturation with three hundred full-scale samples
      scen = "R3";
      step(0, 0, 1, 0);
      for (int i = 0; i < 300; i++) step(1, 4095, 0, 0);
      step(0, 0, 0, 1);
      idle(1);

      // R11: single-sample window
      scen = "R11";
      step(1, 800, 1, 1);
      idle(2);

      // R5: short window with two samples only
      scen = "R5";
      step(1, 8, 1, 0);
      step(1, 12, 0, 1);
      idle(2);

      // R10: long quiet stretch, values must hold
      scen = "R10";
      idle(20);

      // R2: back-to-back windows
      scen = "R2";
      step(1, 1000, 1, 0);
      step(1, 1001, 0, 1);
      step(1, 500, 1, 1);
      idle(3);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule